// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Master

This block fetches a run of consecutive 16-bit words from a three-wire serial EEPROM. The host raises a one-cycle start request with a first address, a word count and a width select. The width select picks 6-bit or 8-bit addressing. For every word the block runs one complete read instruction on the serial lines and collects the reply. It then offers the word on a valid/ready output. When the last word has been taken, it raises a one-cycle done pulse.

Each instruction follows the same order. Chip select goes high for one quiet serial-clock period. The block then shifts out a start bit, the read opcode and the address, most significant bit first. It clocks in seventeen reply bits and discards the leading dummy zero. Chip select then falls and stays low for at least one full serial-clock period before the next instruction. Both serial-clock phases are counted in system clocks, and their lengths are set by two parameters.

Top module: `mw_seq_reader`

## Requirements
- R1: After reset and whenever no run is active, chip select, serial clock, data-out, valid, busy and done are all low.
- R2: Each instruction opens with chip select high for exactly one serial-clock period (one rising edge) with data-out low, before the start bit.
- R3: The bits sent after that are 1 (start), then 1 and 0 (read opcode), then the address MSB first. The address is 8 bits when `i_wide`=1 and 6 bits when `i_wide`=0. For word k the address is (first address + k) modulo 2^width.
- R4: Data-in is sampled at the system clock edge on which the serial clock rises. Seventeen bits are sampled per word. The first is dropped and the remaining sixteen form the word, MSB first.
- R5: Data-out never changes while the serial clock stays high.
- R6: Chip select falls right after the seventeenth reply bit, at the same edge on which valid rises. It then stays low for at least HI_CYC+LO_CYC system clocks before the next instruction.
- R7: The serial clock is high for exactly HI_CYC system clocks per pulse. While chip select is high, it is low for exactly LO_CYC system clocks before each rising edge.
- R8: Valid stays high and the word stays unchanged until ready is seen. Chip select stays low while valid is high, so no new instruction starts before the word is accepted.
- R9: Exactly `i_count` words are delivered, in ascending address order. After the last word is accepted, done pulses for one cycle and busy falls. A count of zero gives a done pulse and no instruction.
- R10: A start request that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | One-cycle run request, taken only while idle |
| i_addr | input | 8 | First word address |
| i_count | input | CNT_W | Number of words to read |
| i_wide | input | 1 | 1: 8-bit addressing, 0: 6-bit addressing |
| o_busy | output | 1 | A run is in progress |
| o_done | output | 1 | One-cycle pulse after the last word is accepted |
| o_cs | output | 1 | Chip select to the memory |
| o_sck | output | 1 | Serial clock to the memory |
| o_sdo | output | 1 | Serial data to the memory |
| i_sdi | input | 1 | Serial data from the memory |
| o_valid | output | 1 | Word available |
| i_ready | input | 1 | Word taken when high with valid |
| o_data | output | 16 | Word read from the memory |

## Verification
The bench builds the block with HI_CYC=3 and LO_CYC=2. This keeps each instruction near 150 system clocks, so runs that wrap the 6-bit and 8-bit address spaces fit easily into the run. The two phase lengths are unequal, so a swap of the high and low counts shows up directly in the measured pulse widths. A gated ready pattern holds words back across several serial-clock periods, which exercises the hold path and the stretched chip-select gap.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;

    localparam int ADDR_MAX_W = 8;
    localparam int WORD_W     = 16;
    localparam int HDR_W      = 3;                     // start bit + 2 opcode bits
    localparam int FRAME_W    = HDR_W + ADDR_MAX_W;
    localparam int REPLY_BITS = WORD_W + 1;            // dummy zero + data
    localparam int BITCNT_W   = 5;

    localparam logic [HDR_W-1:0] RD_HDR = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_CMD,
        ST_READ,
        ST_DESEL,
        ST_HOLD
    } rd_state_t;

    // Left-aligned outgoing frame; short addresses are padded at the bottom.
    function automatic logic [FRAME_W-1:0] build_frame(input logic wide,
                                                       input logic [ADDR_MAX_W-1:0] addr);
        if (wide)
            return {RD_HDR, addr};
        else
            return {RD_HDR, addr[5:0], 2'b00};
    endfunction

    // Index of the last frame bit, counted down from here.
    function automatic logic [BITCNT_W-1:0] frame_last(input logic wide);
        return wide ? BITCNT_W'(FRAME_W - 1) : BITCNT_W'(FRAME_W - 3);
    endfunction

endpackage

// File: rtl/mw_bit_timer.sv
module mw_bit_timer #(
    parameter int HI_CYC = 38,
    parameter int LO_CYC = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic i_run,
    output logic o_sck,
    output logic o_rise,
    output logic o_end
);
    localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic          phase;
    logic [CW-1:0] cnt;

    assign o_rise = i_run && !phase && (cnt == CW'(LO_CYC - 1));
    assign o_end  = i_run &&  phase && (cnt == CW'(HI_CYC - 1));
    assign o_sck  = phase;

    always_ff @(posedge clk) begin
        if (rst || !i_run) begin
            phase <= 1'b0;
            cnt   <= '0;
        end else if (o_rise) begin
            phase <= 1'b1;
            cnt   <= '0;
        end else if (o_end) begin
            phase <= 1'b0;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mw_frame_tx.sv
module mw_frame_tx
    import mw_rd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  i_load,
    input  logic                  i_wide,
    input  logic [ADDR_MAX_W-1:0] i_addr,
    input  logic                  i_shift,
    output logic                  o_bit
);
    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (i_load)
            sr <= build_frame(i_wide, i_addr);
        else if (i_shift)
            sr <= {sr[FRAME_W-2:0], 1'b0};
    end

    assign o_bit = sr[FRAME_W-1];
endmodule

// File: rtl/mw_reply_rx.sv
module mw_reply_rx
    import mw_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_clear,
    input  logic              i_cap,
    input  logic              i_bit,
    output logic [WORD_W-1:0] o_word
);
    // The dummy zero falls off the top after all reply bits are shifted in.
    always_ff @(posedge clk) begin
        if (rst || i_clear)
            o_word <= '0;
        else if (i_cap)
            o_word <= {o_word[WORD_W-2:0], i_bit};
    end
endmodule

// File: rtl/mw_seq_reader.sv
module mw_seq_reader
    import mw_rd_pkg::*;
#(
    parameter int HI_CYC = 38,
    parameter int LO_CYC = 13,
    parameter int CNT_W  = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  i_start,
    input  logic [ADDR_MAX_W-1:0] i_addr,
    input  logic [CNT_W-1:0]      i_count,
    input  logic                  i_wide,
    output logic                  o_busy,
    output logic                  o_done,
    output logic                  o_cs,
    output logic                  o_sck,
    output logic                  o_sdo,
    input  logic                  i_sdi,
    output logic                  o_valid,
    input  logic                  i_ready,
    output logic [WORD_W-1:0]     o_data
);
    rd_state_t             state;
    logic [ADDR_MAX_W-1:0] addr;
    logic [CNT_W-1:0]      left;
    logic                  wide;
    logic [BITCNT_W-1:0]   bits;
    logic                  t_run, t_rise, t_end;
    logic                  frame_bit;

    assign t_run = (state == ST_SEL) || (state == ST_CMD) ||
                   (state == ST_READ) || (state == ST_DESEL);

    mw_bit_timer #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .i_run  (t_run),
        .o_sck  (o_sck),
        .o_rise (t_rise),
        .o_end  (t_end)
    );

    mw_frame_tx i_tx (
        .clk     (clk),
        .rst     (rst),
        .i_load  (state == ST_SEL),
        .i_wide  (wide),
        .i_addr  (addr),
        .i_shift ((state == ST_CMD) && t_end),
        .o_bit   (frame_bit)
    );

    mw_reply_rx i_rx (
        .clk     (clk),
        .rst     (rst),
        .i_clear (state == ST_SEL),
        .i_cap   ((state == ST_READ) && t_rise),
        .i_bit   (i_sdi),
        .o_word  (o_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr    <= '0;
            left    <= '0;
            wide    <= 1'b0;
            bits    <= '0;
            o_valid <= 1'b0;
            o_done  <= 1'b0;
        end else begin
            o_done <= 1'b0;
            if (o_valid && i_ready)
                o_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (i_start) begin
                        addr <= i_addr;
                        wide <= i_wide;
                        left <= i_count;
                        if (i_count == '0)
                            o_done <= 1'b1;
                        else
                            state <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (t_end) begin
                        state <= ST_CMD;
                        bits  <= frame_last(wide);
                    end
                end
                ST_CMD: begin
                    if (t_end) begin
                        if (bits == '0) begin
                            state <= ST_READ;
                            bits  <= BITCNT_W'(REPLY_BITS - 1);
                        end else begin
                            bits <= bits - 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (t_end) begin
                        if (bits == '0) begin
                            state   <= ST_DESEL;
                            o_valid <= 1'b1;
                            left    <= left - 1'b1;
                        end else begin
                            bits <= bits - 1'b1;
                        end
                    end
                end
                ST_DESEL: begin
                    if (t_end) begin
                        if (o_valid && !i_ready)
                            state <= ST_HOLD;
                        else if (left == '0) begin
                            state  <= ST_IDLE;
                            o_done <= 1'b1;
                        end else begin
                            state <= ST_SEL;
                            addr  <= addr + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (i_ready) begin
                        if (left == '0) begin
                            state  <= ST_IDLE;
                            o_done <= 1'b1;
                        end else begin
                            state <= ST_SEL;
                            addr  <= addr + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign o_busy = (state != ST_IDLE);
    assign o_cs   = (state == ST_SEL) || (state == ST_CMD) || (state == ST_READ);
    assign o_sdo  = (state == ST_CMD) && frame_bit;
endmodule

// File: rtl/mw_seq_reader_chk.sv
module mw_seq_reader_chk #(
    parameter int HI_CYC = 38,
    parameter int LO_CYC = 13
) (
    input logic        clk,
    input logic        rst,
    input logic        o_busy,
    input logic        o_done,
    input logic        o_cs,
    input logic        o_sck,
    input logic        o_sdo,
    input logic        o_valid,
    input logic        i_ready,
    input logic [15:0] o_data
);
    logic [15:0] hi_run, lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= o_sck ? hi_run + 1'b1 : 16'd0;
            lo_run <= (o_cs && !o_sck) ? lo_run + 1'b1 : 16'd0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !o_busy |-> (!o_cs && !o_sck && !o_sdo && !o_valid));                 // R1
    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (o_sck && $past(o_sck)) |-> $stable(o_sdo));                          // R5
    AST_SCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(o_sck) |-> (hi_run == 16'(HI_CYC)));                            // R7
    AST_SCK_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(o_sck) && o_cs) |-> (lo_run == 16'(LO_CYC)));                  // R7
    AST_CS_DROP_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        $fell(o_cs) |-> $rose(o_valid));                                      // R6
    AST_VALID_CS_LOW: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> !o_cs);                                                   // R8
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !i_ready) |=> (o_valid && $stable(o_data)));              // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        o_done |=> !o_done);                                                  // R9
endmodule

bind mw_seq_reader mw_seq_reader_chk #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .o_busy  (o_busy),
    .o_done  (o_done),
    .o_cs    (o_cs),
    .o_sck   (o_sck),
    .o_sdo   (o_sdo),
    .o_valid (o_valid),
    .i_ready (i_ready),
    .o_data  (o_data)
);

// File: tb/test_mw_seq_reader.sv
module test_mw_seq_reader;
    localparam int HI = 3;
    localparam int LO = 2;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    addr_in = '0;
    logic [CW-1:0] count_in = '0;
    logic          wide_in = 1'b0;
    logic          busy, done, cs, sck, sdo, valid;
    logic          sdi = 1'b0;
    logic          ready = 1'b1;
    logic [15:0]   data;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mw_seq_reader #(.HI_CYC(HI), .LO_CYC(LO), .CNT_W(CW)) i_mw_seq_reader (
        .clk(clk), .rst(rst), .i_start(start), .i_addr(addr_in), .i_count(count_in),
        .i_wide(wide_in), .o_busy(busy), .o_done(done), .o_cs(cs), .o_sck(sck),
        .o_sdo(sdo), .i_sdi(sdi), .o_valid(valid), .i_ready(ready), .o_data(data)
    );

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return {a, ~a} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // memory model and monitors, all sampled on the falling system clock edge
    logic        cur_wide = 1'b0;
    bit          bp = 1'b0;
    int          cyc = 0;
    int          dst = 0, nb = 0, nd = 0, pre = 0;
    logic [7:0]  sh = '0;
    logic [15:0] word = '0;
    logic [7:0]  dev_addr [0:31];
    int          dev_pre [0:31];
    logic [15:0] got [0:31];
    int          dev_n = 0, got_n = 0, op_err = 0, done_n = 0, got_at_done = 0;
    int          hi_run = 0, lo_run = 0, hi_bad = 0, lo_bad = 0, sdo_bad = 0;
    int          hold_bad = 0, csv_bad = 0, gap_run = 0, gap_min = 9999, cs_rises = 0;
    bit          seen_word = 0;
    logic        p_sck = 0, p_sdo = 0, p_valid = 0, p_ready = 1, p_cs = 0;
    logic [15:0] p_data = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            // memory model
            if (!cs) begin
                dst = 0; pre = 0; sdi = 1'b0;
            end else if (sck && !p_sck) begin
                case (dst)
                    0: if (sdo) begin dst = 1; nb = 0; sh = '0; dev_pre[dev_n] = pre; end
                       else pre++;
                    1: begin
                        sh = {sh[6:0], sdo}; nb++;
                        if (nb == 2) begin
                            if (sh[1:0] != 2'b10) op_err++;
                            dst = 2; nb = 0; sh = '0;
                        end
                    end
                    2: begin
                        sh = {sh[6:0], sdo}; nb++;
                        if (nb == (cur_wide ? 8 : 6)) begin
                            dev_addr[dev_n] = sh; word = mem_word(sh); dev_n++;
                            dst = 3; nd = 0; sdi = 1'b0;
                        end
                    end
                    3: if (nd < 16) begin sdi = word[15-nd]; nd++; end
                       else begin sdi = 1'b0; dst = 4; end
                    default: ;
                endcase
            end
            // pulse widths
            if (sck) hi_run++;
            else if (p_sck) begin if (hi_run != HI) hi_bad++; hi_run = 0; end
            if (sck && !p_sck && cs) begin if (lo_run != LO) lo_bad++; lo_run = 0; end
            else if (cs && !sck) lo_run++;
            else lo_run = 0;
            if (sck && p_sck && sdo != p_sdo) sdo_bad++;
            // chip-select gap between words
            if (cs && !p_cs) begin
                cs_rises++;
                if (seen_word && gap_run < gap_min) gap_min = gap_run;
                gap_run = 0;
            end
            if (!cs && p_cs) seen_word = 1;
            if (busy && !cs) gap_run++;
            // handshake
            if (p_valid && !p_ready && (!valid || data != p_data)) hold_bad++;
            if (valid && cs) csv_bad++;
            ready = bp ? ((cyc % 11) == 3) : 1'b1;
            if (valid && ready) begin got[got_n] = data; got_n++; end
            if (done) begin done_n++; got_at_done = got_n; end
        end
        p_sck = sck; p_sdo = sdo; p_valid = valid; p_ready = ready;
        p_cs = cs; p_data = data;
    end

    task automatic clear_logs();
        dev_n = 0; got_n = 0; op_err = 0; done_n = 0; got_at_done = 0;
        hi_bad = 0; lo_bad = 0; sdo_bad = 0; hold_bad = 0; csv_bad = 0;
        gap_min = 9999; gap_run = 0; cs_rises = 0; seen_word = 0;
    endtask

    task automatic run_case(input string tag, input logic [7:0] a, input int cnt,
                            input logic w, input bit use_bp, input bit poke);
        int mism_a, mism_d, mism_p, waited;
        logic [7:0] mask, ea;
        clear_logs();
        bp = use_bp; cur_wide = w;
        mask = w ? 8'hFF : 8'h3F;
        @(negedge clk);
        start = 1'b1; addr_in = a; count_in = CW'(cnt); wide_in = w;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (done_n == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 60) begin
                start = 1'b1; addr_in = 8'hA0; count_in = CW'(5); wide_in = ~w;
            end else start = 1'b0;
        end
        @(negedge clk);
        mism_a = 0; mism_d = 0; mism_p = 0;
        for (int k = 0; k < cnt; k++) begin
            ea = (a + 8'(k)) & mask;
            if (k < dev_n) begin
                if (dev_addr[k] != ea) begin
                    mism_a++;
                    $display("%s word %0d address %0d vs %0d", tag, k, dev_addr[k], ea);
                end
                if (dev_pre[k] != 1) mism_p++;
            end
            if (k < got_n && got[k] != mem_word(ea)) begin
                mism_d++;
                $display("%s word %0d data %0d vs %0d", tag, k, got[k], mem_word(ea));
            end
        end
        chk(got_n == cnt, "R9", {tag, " words delivered"}, got_n, cnt);
        chk(dev_n == cnt, poke ? "R10" : "R3", {tag, " instructions issued"}, dev_n, cnt);
        chk(mism_a == 0, "R3", {tag, " address sequence mismatches"}, mism_a, 0);
        chk(op_err == 0, "R3", {tag, " start/opcode errors"}, op_err, 0);
        chk(mism_d == 0, "R4", {tag, " data word mismatches"}, mism_d, 0);
        chk(mism_p == 0, "R2", {tag, " select periods not equal to one"}, mism_p, 0);
        chk(sdo_bad == 0, "R5", {tag, " data-out changes while clock high"}, sdo_bad, 0);
        chk(hi_bad == 0 && lo_bad == 0, "R7", {tag, " clock phase width errors"},
            hi_bad + lo_bad, 0);
        if (cnt > 1)
            chk(gap_min >= HI + LO, "R6", {tag, " minimum deselect gap"}, gap_min, HI + LO);
        chk(hold_bad == 0 && csv_bad == 0, "R8", {tag, " handshake hold errors"},
            hold_bad + csv_bad, 0);
        chk(done_n == 1 && got_at_done == cnt, "R9", {tag, " done after last word"},
            got_at_done, cnt);
        chk(!busy && !cs, "R1", {tag, " quiet after run"}, int'(busy) + int'(cs), 0);
    endtask

    task automatic t_reset();
        chk(!cs && !sck && !sdo && !valid && !busy && !done, "R1", "reset outputs",
            int'(cs) + int'(sck) + int'(sdo) + int'(valid) + int'(busy) + int'(done), 0);
    endtask

    task automatic t_wide_run();     run_case("wide",   8'h3E, 4, 1'b1, 0, 0); endtask
    task automatic t_narrow_wrap();  run_case("narrow", 8'h3E, 3, 1'b0, 0, 0); endtask
    task automatic t_backpressure(); run_case("bp",     8'hFE, 3, 1'b1, 1, 0); endtask
    task automatic t_busy_start();   run_case("poke",   8'h20, 2, 1'b1, 0, 1); endtask

    task automatic t_zero_count();
        clear_logs(); bp = 0;
        @(negedge clk);
        start = 1'b1; addr_in = 8'h05; count_in = '0; wide_in = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(done_n == 1, "R9", "zero count done pulses", done_n, 1);
        chk(cs_rises == 0, "R9", "zero count chip selects", cs_rises, 0);
        chk(!busy, "R1", "zero count idle", int'(busy), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide_run();
        t_narrow_wrap();
        t_backpressure();
        t_zero_count();
        t_busy_start();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule